// File: doc/BRIEF.md
# SDRAM Read Burst Sequencer

This block is a synthesizable, device-side model of a two-bank SDRAM with a 16-bit data word. It takes already-decoded commands on a rising clock edge. It keeps track of which row is open in each bank and holds a small mode register for CAS latency and burst length. For reads, it produces a burst of data words with an output-enable window, and the burst's column sequence can wrap. A simple single-word write path fills the storage array. The array is indexed by bank, row and column. Only a few rows per bank are modelled (parameter `ROW_BITS`), and the low address bits select among them.

A controller or testbench drives `cmd`, `addr` and `wdata` and watches `rdata`, `rdata_valid` and `rdata_oe`. `rdata_oe` stands in for the tri-state enable of a real data bus. Two one-cycle flags report protocol misuse:
- `trcd_err` marks an access issued too soon after its bank was opened.
- `bank_err` marks an access to a bank that is not open.

Top module: `sdr_burst_model`

## Requirements
- R1: Commands on `cmd` are encoded as 0 idle, 1 open bank, 2 read, 3 write, 4 burst stop, 5 mode set, 6 close bank. After reset, both banks are closed and `rdata_valid`, `rdata_oe`, `trcd_err` and `bank_err` are low. The mode register starts at CAS latency 2 and burst length 4.
- R2: An open-bank command opens the bank given by `addr[11]` at the row in `addr[ROW_BITS-1:0]`. A write that is accepted stores `wdata` at that bank's open row, in the column given by `addr[7:0]`. A later read of that location returns the stored word.
- R3: A read or write taken fewer than `TRCD` edges after its bank was opened raises `trcd_err` for exactly the next cycle. The command is otherwise ignored: nothing is stored and no burst starts.
- R4: A mode set command loads the CAS latency from `addr[5:4]` (values 1, 2 or 3; 0 is taken as 1). For a read accepted at edge e, the first word is on `rdata` with `rdata_valid` high in the cycle that follows edge e+CL.
- R5: For a read accepted at edge e, `rdata_oe` rises in the cycle after edge e+CL-1, which is one cycle before the first word. It stays high through the last word and is low in the cycle after the last word.
- R6: A mode set command loads the burst length code from `addr[2:0]` as follows: 000 gives 1 word, 001 gives 2, 010 gives 4, 011 gives 8, and 111 gives a full page. Codes 100 to 110 give 1 word.
- R7: For bursts of 2, 4 and 8, word i comes from the column that keeps the start column's bits above the burst size and adds i to the low bits modulo the burst size, so the burst wraps inside the aligned block.
- R8: In full-page mode, words continue from consecutive columns and wrap modulo 256 until a burst stop command arrives. After the edge that takes a burst stop, `rdata_valid` and `rdata_oe` are both low.
- R9: A read accepted while a burst is running abandons that burst. The new burst follows the timing of R4 and R5, counted from the new read.
- R10: A close-bank command closes the bank given by `addr[11]`. A read or write to a closed bank raises `bank_err` for the next cycle, stores nothing and starts no burst. If a bank is closed and its tRCD window has also not elapsed, only `bank_err` is raised.
- R11: `rdata_valid` is high only in the cycles that carry burst words, one word per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are taken on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | Decoded command code (see R1) |
| addr | input | 12 | Bank select in bit 11; row, column or mode fields below it |
| wdata | input | 16 | Word stored by an accepted write |
| rdata | output | 16 | Burst read data; meaningful while `rdata_valid` is high |
| rdata_valid | output | 1 | High in each cycle that carries a burst word |
| rdata_oe | output | 1 | Output-enable window around the burst |
| trcd_err | output | 1 | One-cycle flag for an access that came too soon after open |
| bank_err | output | 1 | One-cycle flag for an access to a closed bank |

## Verification
The assertions rely on three assumptions about the inputs:
- `cmd` never carries the unused code 7.
- No write targets the row and column that a running burst is fetching.
- A full-page burst is always ended by a burst stop or a new read.

The stimulus stays inside these limits. It issues only the named commands, completes every write fill before the reads that depend on it, and stops every full-page burst well within the bench's reference window. Reads are aimed only at locations that have already been written, so each returned word has a defined expected value.

// File: rtl/sdr_burst_model.sv
module sdr_burst_model #(
  parameter int ROW_BITS = 2,
  parameter int TRCD     = 2,
  parameter int DW       = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    cmd,
  input  logic [11:0]   addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rdata_valid,
  output logic          rdata_oe,
  output logic          trcd_err,
  output logic          bank_err
);
  localparam int AW    = 1 + ROW_BITS + 8;
  localparam int DEPTH = 1 << AW;
  localparam int CW    = (TRCD > 1) ? $clog2(TRCD) : 1;
  localparam logic [CW-1:0] RCD_OK = CW'((TRCD > 0) ? TRCD - 1 : 0);

  localparam logic [2:0] C_ACT = 3'd1;
  localparam logic [2:0] C_RD  = 3'd2;
  localparam logic [2:0] C_WR  = 3'd3;
  localparam logic [2:0] C_BST = 3'd4;
  localparam logic [2:0] C_MRS = 3'd5;
  localparam logic [2:0] C_PRE = 3'd6;

  logic [DW-1:0]       mem [DEPTH];
  logic [1:0]          bank_open;
  logic [ROW_BITS-1:0] open_row [2];
  logic [CW-1:0]       rcd [2];
  logic [1:0]          cas_lat;
  logic [2:0]          bl_code;

  logic                busy;
  logic [1:0]          wait_cnt;
  logic [7:0]          beat;
  logic [7:0]          base_col;
  logic [7:0]          col_mask;
  logic                run_full;
  logic                run_bank;
  logic [ROW_BITS-1:0] run_row;

  logic       sel, is_acc, hit_closed, too_soon, accept, start_rd, do_wr;
  logic       last_beat, streaming;
  logic [7:0] cur_col, new_mask;

  assign sel        = addr[11];
  assign is_acc     = (cmd == C_RD) || (cmd == C_WR);
  assign hit_closed = is_acc && !bank_open[sel];
  assign too_soon   = is_acc && bank_open[sel] && (rcd[sel] < RCD_OK);
  assign accept     = is_acc && !hit_closed && !too_soon;
  assign start_rd   = accept && (cmd == C_RD);
  assign do_wr      = accept && (cmd == C_WR);
  assign cur_col    = (base_col & ~col_mask) | ((base_col + beat) & col_mask);
  assign last_beat  = !run_full && (beat == col_mask);
  assign streaming  = busy && (wait_cnt == 2'd0);

  always_comb begin
    case (bl_code)
      3'd1:    new_mask = 8'h01;
      3'd2:    new_mask = 8'h03;
      3'd3:    new_mask = 8'h07;
      3'd7:    new_mask = 8'hFF;
      default: new_mask = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_open <= 2'b00;
      for (int b = 0; b < 2; b++) begin
        open_row[b] <= '0;
        rcd[b]      <= '0;
      end
    end else begin
      for (int b = 0; b < 2; b++) begin
        if (cmd == C_ACT && sel == 1'(b)) begin
          bank_open[b] <= 1'b1;
          open_row[b]  <= addr[ROW_BITS-1:0];
          rcd[b]       <= '0;
        end else begin
          if (cmd == C_PRE && sel == 1'(b)) bank_open[b] <= 1'b0;
          if (rcd[b] < RCD_OK) rcd[b] <= rcd[b] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cas_lat     <= 2'd2;
      bl_code     <= 3'd2;
      busy        <= 1'b0;
      wait_cnt    <= 2'd0;
      beat        <= 8'd0;
      base_col    <= 8'd0;
      col_mask    <= 8'd0;
      run_full    <= 1'b0;
      run_bank    <= 1'b0;
      run_row     <= '0;
      rdata_oe    <= 1'b0;
      rdata_valid <= 1'b0;
      trcd_err    <= 1'b0;
      bank_err    <= 1'b0;
    end else begin
      trcd_err <= too_soon;
      bank_err <= hit_closed;
      if (cmd == C_MRS) begin
        cas_lat <= (addr[5:4] == 2'd0) ? 2'd1 : addr[5:4];
        bl_code <= addr[2:0];
      end
      if (start_rd) begin
        busy        <= 1'b1;
        wait_cnt    <= cas_lat - 2'd1;
        beat        <= 8'd0;
        base_col    <= addr[7:0];
        col_mask    <= new_mask;
        run_full    <= (bl_code == 3'd7);
        run_bank    <= sel;
        run_row     <= open_row[sel];
        rdata_oe    <= (cas_lat == 2'd1);
        rdata_valid <= 1'b0;
      end else if (cmd == C_BST) begin
        busy        <= 1'b0;
        rdata_oe    <= 1'b0;
        rdata_valid <= 1'b0;
      end else if (busy) begin
        if (wait_cnt != 2'd0) begin
          wait_cnt    <= wait_cnt - 2'd1;
          rdata_oe    <= (wait_cnt == 2'd1);
          rdata_valid <= 1'b0;
        end else begin
          rdata_oe    <= 1'b1;
          rdata_valid <= 1'b1;
          beat        <= beat + 8'd1;
          if (last_beat) busy <= 1'b0;
        end
      end else begin
        rdata_oe    <= 1'b0;
        rdata_valid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[{sel, open_row[sel], addr[7:0]}] <= wdata;
    if (streaming) rdata <= mem[{run_bank, run_row, cur_col}];
  end
endmodule

// File: rtl/sdr_burst_model_chk.sv
module sdr_burst_model_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  cmd,
  input logic [11:0] addr,
  input logic [1:0]  bank_open,
  input logic        rdata_valid,
  input logic        rdata_oe,
  input logic        trcd_err,
  input logic        bank_err
);
  // R5 and R11: a data word never appears outside the enable window
  a_r5_valid_inside_oe: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |-> rdata_oe);

  // R5: the window is already open in the cycle before the first word
  a_r5_oe_leads_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdata_valid) |-> $past(rdata_oe));

  // R5: the window never closes while a word is being presented
  a_r5_oe_tail: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdata_oe) |-> !rdata_valid);

  // R8: a burst stop silences the output on the next cycle
  a_r8_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd4) |=> (!rdata_valid && !rdata_oe));

  // R10: an access to a closed bank is flagged next cycle
  a_r10_closed_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == 3'd2 || cmd == 3'd3) && !bank_open[addr[11]]) |=> bank_err);

  // R3 and R10: the two error flags never fire together
  a_r3_one_error: assert property (@(posedge clk) disable iff (!rst_n)
    !(trcd_err && bank_err));
endmodule

bind sdr_burst_model sdr_burst_model_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .addr(addr), .bank_open(bank_open),
  .rdata_valid(rdata_valid), .rdata_oe(rdata_oe),
  .trcd_err(trcd_err), .bank_err(bank_err)
);

// File: tb/sdr_burst_model_bench.sv
`timescale 1ns/1ps
module sdr_burst_model_bench;
  localparam int ROWB = 2;
  localparam int TRCD = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd = 3'd0;
  logic [11:0] addr = 12'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        rdata_valid, rdata_oe, trcd_err, bank_err;

  sdr_burst_model #(.ROW_BITS(ROWB), .TRCD(TRCD), .DW(16)) u_sdr_burst_model (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdata_valid(rdata_valid), .rdata_oe(rdata_oe),
    .trcd_err(trcd_err), .bank_err(bank_err));

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit chk_on = 0, done = 0;
  string tag = "R1";

  bit          eo[int], ev[int], et[int], eb[int];
  logic [15:0] ed[int];
  logic [15:0] mm[int];
  bit opn[2];
  int orow[2], aedge[2];
  int m_cl = 2, m_bl = 4;
  bit m_full = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int key(int b, int r, int c);
    return b * 1024 + r * 256 + c;
  endfunction

  function automatic logic [15:0] pat(int b, int r, int c);
    return 16'((b << 15) ^ (r << 12) ^ (c * 37) ^ 16'h00A5);
  endfunction

  task automatic clear_from(int e);
    for (int k = e; k < e + 700; k++) begin
      eo.delete(k);
      ev.delete(k);
      ed.delete(k);
    end
  endtask

  task automatic model(int c, int a, int w, int e);
    int b = (a >> 11) & 1;
    case (c)
      1: begin opn[b] = 1; orow[b] = a & ((1 << ROWB) - 1); aedge[b] = e; end
      2, 3: begin
        if (!opn[b]) eb[e] = 1;
        else if (e - aedge[b] < TRCD) et[e] = 1;
        else if (c == 3) mm[key(b, orow[b], a & 255)] = 16'(w);
        else begin
          int n = m_full ? 600 : m_bl;
          int c0 = a & 255;
          int msk = m_full ? 255 : m_bl - 1;
          clear_from(e);
          for (int k = e + m_cl - 1; k <= e + m_cl + n - 1; k++) eo[k] = 1;
          for (int i = 0; i < n; i++) begin
            int col = (c0 & ~msk & 255) | ((c0 + i) & msk);
            ev[e + m_cl + i] = 1;
            ed[e + m_cl + i] = mm.exists(key(b, orow[b], col)) ? mm[key(b, orow[b], col)] : 16'hxxxx;
          end
        end
      end
      4: clear_from(e);
      5: begin
        m_cl = ((a >> 4) & 3) == 0 ? 1 : ((a >> 4) & 3);
        case (a & 7)
          1: begin m_bl = 2; m_full = 0; end
          2: begin m_bl = 4; m_full = 0; end
          3: begin m_bl = 8; m_full = 0; end
          7: begin m_bl = 256; m_full = 1; end
          default: begin m_bl = 1; m_full = 0; end
        endcase
      end
      6: opn[b] = 0;
      default: ;
    endcase
  endtask

  task automatic check(string what, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s at edge %0d: got %h expected %h", tag, what, cyc, got, exp);
    end
  endtask

  always @(negedge clk) if (chk_on) begin
    check("rdata_oe", 16'(rdata_oe), 16'(eo.exists(cyc) ? eo[cyc] : 1'b0));
    check("rdata_valid", 16'(rdata_valid), 16'(ev.exists(cyc) ? ev[cyc] : 1'b0));
    check("trcd_err", 16'(trcd_err), 16'(et.exists(cyc) ? et[cyc] : 1'b0));
    check("bank_err", 16'(bank_err), 16'(eb.exists(cyc) ? eb[cyc] : 1'b0));
    if (ev.exists(cyc) && ev[cyc]) check("rdata", rdata, ed[cyc]);
  end

  task automatic issue(int c, int a, int w = 0);
    @(negedge clk);
    cmd = 3'(c); addr = 12'(a); wdata = 16'(w);
    model(c, a, w, cyc + 1);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) issue(0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk_on = 1;
    tag = "R1";
    idle(3);
    tag = "R10";                 // read before any bank is opened
    issue(2, 0);
    idle(2);
    tag = "R3";                  // write one edge after open is refused
    issue(1, 1);
    issue(3, 0, 16'hDEAD);
    idle(1);
    tag = "R2";
    for (int c = 0; c < 256; c++) issue(3, c, pat(0, 1, c));
    issue(1, (1 << 11) | 2);
    idle(2);
    for (int c = 0; c < 16; c++) issue(3, (1 << 11) | c, pat(1, 2, c));
    issue(2, 3);                 // default mode: CL2, four words
    idle(10);
    tag = "R7";
    issue(2, 5);
    idle(10);
    issue(5, (1 << 4) | 3);
    issue(2, 13);
    issue(0, 0);
    issue(2, (1 << 11) | 10);
    idle(14);
    tag = "R4";
    for (int l = 1; l <= 3; l++) begin
      issue(5, l << 4);
      issue(2, 20 + l * 7);
      idle(8);
    end
    tag = "R6";
    for (int bc = 0; bc < 8; bc++) begin
      issue(5, (3 << 4) | (bc == 7 ? 4 : bc));
      issue(2, 60 + bc * 9);
      idle(14);
    end
    tag = "R5";
    issue(5, (1 << 4) | 1);
    issue(2, 101);
    idle(6);
    tag = "R11";
    issue(5, (2 << 4) | 2);
    issue(2, 200);
    idle(3);
    issue(2, (1 << 11) | 6);
    idle(10);
    tag = "R8";
    issue(5, (2 << 4) | 7);
    issue(2, 250);
    idle(290);
    issue(4, 0);
    idle(5);
    tag = "R9";
    issue(5, (3 << 4) | 3);
    issue(2, 40);
    idle(5);
    issue(2, (1 << 11) | 9);
    idle(14);
    issue(5, (1 << 4) | 2);
    issue(2, 77);
    issue(0, 0);
    issue(2, 130);
    idle(8);
    tag = "R10";
    issue(6, 1 << 11);
    issue(2, 1 << 11);
    issue(3, (1 << 11) | 9, 16'hBEEF);
    idle(2);
    issue(1, (1 << 11) | 2);
    idle(2);
    issue(5, (1 << 4) | 0);
    issue(2, (1 << 11) | 9);
    idle(4);
    tag = "R3";
    issue(1, 1);
    issue(3, 3, 16'hDEAD);
    idle(1);
    issue(2, 3);
    issue(1, (1 << 11) | 2);
    issue(2, (1 << 11) | 4);
    idle(5);
    chk_on = 0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule